// File: doc/BRIEF.md
# Interrupt Enable and Status Unit

This block holds the interrupt enable register and the interrupt status register for each locality of a multi-locality command interface. It has five localities by default. Event pulses come in from the command engine and from the locality arbiter. The unit records an event in the status register of the locality it names, but only when that locality's global enable and the enable for that event source are both set. A single shared interrupt request line is driven from the recorded events. Software reads these registers and writes them with byte, halfword or word accesses. The unit builds a lane mask from the access size and the byte offset, so a narrow write changes only the lanes it addresses.

Only the locality that currently owns the interface can change its own registers. A write from any other locality, or a write made while no locality owns the interface, is dropped. The unit also has a read-only vector register. It returns the interrupt number fixed by a 4-bit parameter, so the number always lies between 0 and 15.

The shared line is controlled by a two-state machine:
- LINE_QUIET moves to LINE_RAISED when any locality records an event.
- LINE_RAISED moves back to LINE_QUIET when a clearing write leaves the writing locality's status at zero, and no event is recorded in that same cycle.

Top module: `irq_enable_status_unit`

## Requirements
- R1: Reads are combinational. `rd_data` shows the register of locality `acc_loc` that `acc_sel` selects: 0 is enable, 1 is status, 2 is vector. Select 3, or a locality number of at least NUM_LOC, reads as zero. Writes and events become visible after the next rising clock edge.
- R2: Only bit 31 (global enable), bits 4:3 (polarity) and the source bits 0 (data available), 1 (status valid), 2 (locality changed) and 7 (command ready) can be written in the enable register. A write of all ones therefore reads back as 0x8000_009F.
- R3: An event pulse on `ev_src` for locality `ev_loc` sets a status bit only when the global enable bit and that source's enable bit are both 1. The `ev_src` bits map to status bits as follows: `ev_src` bit 0 to bit 0, bit 1 to bit 1, bit 2 to bit 2, bit 3 to bit 7. Each recorded event raises `irq_req`.
- R4: Writing 1s to the status register clears the matching supported bits (mask 0x87). When such a write clears at least one set bit and leaves that locality's status at zero, `irq_req` falls. An event recorded in the same cycle wins over the clear.
- R5: Enable and status writes take effect only when `active_valid` is 1 and `acc_loc` equals `active_loc`. All other writes leave the registers unchanged.
- R6: The vector register reads back as IRQ_NUM in bits 3:0 and zero in the bits above. Writes to it have no effect.
- R7: After reset, every locality's enable register reads 0x0000_0008 (polarity 01, low level) and its status reads 0, and `irq_req` is 0.
- R8: `acc_size` selects the access width: 0 is a byte, 1 is a halfword, 2 or 3 is a word. Write data in the low lanes is shifted up by 8×`acc_off` bits, and only the lanes this covers are updated.
- R9: An event whose `ev_loc` is NUM_LOC or higher (no owner) is dropped. No status bit changes and `irq_req` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| active_valid | input | 1 | A locality owns the interface |
| active_loc | input | 3 | Owning locality |
| acc_loc | input | 3 | Locality of the register access |
| acc_sel | input | 2 | Register select: 0 enable, 1 status, 2 vector |
| acc_off | input | 2 | Byte offset of the access |
| acc_size | input | 2 | Access width: 0 byte, 1 halfword, 2/3 word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data, right-aligned |
| rd_data | output | 32 | Read data for the selected register |
| ev_loc | input | 3 | Locality the event pulses belong to |
| ev_src | input | 4 | Event pulses: command ready, locality changed, status valid, data available (bit 3 to bit 0) |
| irq_req | output | 1 | Shared interrupt request, active high |

## Verification
The bench builds the unit with NUM_LOC = 5 and IRQ_NUM = 11. With five localities, locality numbers 5 to 7 of the 3-bit fields are unused, so reads and events for a locality with no owner can be driven from the bench. The non-zero vector value shows that the vector read is not simply returning a reset value. Locality 1 is the owner for most of the run, and locality 0 is used to send writes from a non-owner.

// File: rtl/irq_esu_pkg.sv
package irq_esu_pkg;

    localparam int unsigned REG_W = 32;

    localparam int unsigned BIT_GLOBAL = 31;
    localparam int unsigned BIT_DAVAIL = 0;
    localparam int unsigned BIT_STSVAL = 1;
    localparam int unsigned BIT_LOCCHG = 2;
    localparam int unsigned BIT_CMDRDY = 7;

    localparam logic [REG_W-1:0] SRC_MASK    = 32'h0000_0087;
    localparam logic [REG_W-1:0] POL_MASK    = 32'h0000_0018;
    localparam logic [REG_W-1:0] EN_WRITABLE = SRC_MASK | POL_MASK | 32'h8000_0000;
    localparam logic [REG_W-1:0] EN_RESET    = 32'h0000_0008;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_VECTOR = 2'd2,
        SEL_RSVD   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } acc_size_e;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;

endpackage

// File: rtl/esu_lane_mask.sv
module esu_lane_mask
    import irq_esu_pkg::*;
(
    input  logic [1:0]       size_i,
    input  logic [1:0]       off_i,
    input  logic [REG_W-1:0] data_i,
    output logic [REG_W-1:0] mask_o,
    output logic [REG_W-1:0] data_o
);

    logic [REG_W-1:0] base;
    logic [4:0]       sh;

    always_comb begin
        unique case (acc_size_e'(size_i))
            SZ_BYTE: base = 32'h0000_00FF;
            SZ_HALF: base = 32'h0000_FFFF;
            SZ_WORD,
            SZ_WORD2: base = '1;
        endcase
        sh     = {off_i, 3'b000};
        mask_o = base << sh;
        data_o = (data_i & base) << sh;
    end

endmodule

// File: rtl/esu_loc_regs.sv
module esu_loc_regs
    import irq_esu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wr_sts_i,
    input  logic [REG_W-1:0] mask_i,
    input  logic [REG_W-1:0] data_i,
    input  logic             ev_hit_i,
    input  logic [3:0]       ev_src_i,
    output logic [REG_W-1:0] en_q,
    output logic [REG_W-1:0] sts_q,
    output logic             rec_o,
    output logic             drop_o
);

    logic [REG_W-1:0] src_vec;
    logic [REG_W-1:0] rec_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] en_d;
    logic [REG_W-1:0] sts_d;

    always_comb begin
        src_vec             = '0;
        src_vec[BIT_DAVAIL] = ev_src_i[0];
        src_vec[BIT_STSVAL] = ev_src_i[1];
        src_vec[BIT_LOCCHG] = ev_src_i[2];
        src_vec[BIT_CMDRDY] = ev_src_i[3];

        rec_vec = (ev_hit_i && en_q[BIT_GLOBAL]) ? (src_vec & en_q & SRC_MASK) : '0;
        clr_vec = wr_sts_i ? (data_i & mask_i & SRC_MASK) : '0;

        sts_d = (sts_q & ~clr_vec) | rec_vec;
        en_d  = wr_en_i ? ((en_q & ~mask_i) | (data_i & mask_i & EN_WRITABLE)) : en_q;

        rec_o  = |rec_vec;
        drop_o = (|(clr_vec & sts_q)) && (sts_d == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= EN_RESET;
            sts_q <= '0;
        end else begin
            en_q  <= en_d;
            sts_q <= sts_d;
        end
    end

    AST_NO_SET_WHEN_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[BIT_GLOBAL]) |=> ((sts_q & ~$past(sts_q)) == '0)); // R3

    AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_sts_i) |=> (($past(sts_q) & ~sts_q) == '0)); // R4

    AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i) |=> $stable(en_q)); // R5

endmodule

// File: rtl/esu_line_fsm.sv
module esu_line_fsm
    import irq_esu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rec_any_i,
    input  logic drop_any_i,
    output logic irq_o
);

    line_state_e st_q;
    line_state_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LINE_QUIET;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LINE_QUIET:  if (rec_any_i) st_d = LINE_RAISED;
            LINE_RAISED: if (drop_any_i && !rec_any_i) st_d = LINE_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (st_q == LINE_RAISED);
    end

    AST_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec_any_i) |=> !$rose(irq_o)); // R3

    AST_FALL_NEEDS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(drop_any_i)); // R4

endmodule

// File: rtl/irq_enable_status_unit.sv
module irq_enable_status_unit
    import irq_esu_pkg::*;
#(
    parameter int unsigned NUM_LOC = 5,
    parameter logic [3:0]  IRQ_NUM = 4'd3,
    localparam int unsigned LOC_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_valid,
    input  logic [LOC_W-1:0] active_loc,
    input  logic [LOC_W-1:0] acc_loc,
    input  logic [1:0]       acc_sel,
    input  logic [1:0]       acc_off,
    input  logic [1:0]       acc_size,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    input  logic [LOC_W-1:0] ev_loc,
    input  logic [3:0]       ev_src,
    output logic             irq_req
);

    logic [REG_W-1:0] lane_mask;
    logic [REG_W-1:0] lane_data;
    logic [REG_W-1:0] en_arr  [NUM_LOC];
    logic [REG_W-1:0] sts_arr [NUM_LOC];
    logic [NUM_LOC-1:0] rec_bits;
    logic [NUM_LOC-1:0] drop_bits;
    logic owner_ok;

    assign owner_ok = wr_en && active_valid && (acc_loc == active_loc);

    esu_lane_mask i_lane (
        .size_i (acc_size),
        .off_i  (acc_off),
        .data_i (wr_data),
        .mask_o (lane_mask),
        .data_o (lane_data)
    );

    for (genvar l = 0; l < NUM_LOC; l++) begin : g_loc
        logic hit_acc;
        assign hit_acc = owner_ok && (acc_loc == LOC_W'(l));

        esu_loc_regs i_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en_i  (hit_acc && (reg_sel_e'(acc_sel) == SEL_ENABLE)),
            .wr_sts_i (hit_acc && (reg_sel_e'(acc_sel) == SEL_STATUS)),
            .mask_i   (lane_mask),
            .data_i   (lane_data),
            .ev_hit_i (ev_loc == LOC_W'(l)),
            .ev_src_i (ev_src),
            .en_q     (en_arr[l]),
            .sts_q    (sts_arr[l]),
            .rec_o    (rec_bits[l]),
            .drop_o   (drop_bits[l])
        );
    end

    esu_line_fsm i_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .rec_any_i  (|rec_bits),
        .drop_any_i (|drop_bits),
        .irq_o      (irq_req)
    );

    always_comb begin
        rd_data = '0;
        if (int'(acc_loc) < int'(NUM_LOC)) begin
            unique case (reg_sel_e'(acc_sel))
                SEL_ENABLE: rd_data = en_arr[acc_loc];
                SEL_STATUS: rd_data = sts_arr[acc_loc];
                SEL_VECTOR: rd_data = {28'd0, IRQ_NUM};
                SEL_RSVD:   rd_data = '0;
            endcase
        end
    end

    AST_NO_OWNER_EVENT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(ev_loc) >= int'(NUM_LOC)) && !irq_req) |=> !irq_req); // R9

endmodule

// File: tb/test_irq_enable_status_unit.sv
module test_irq_enable_status_unit;

    localparam int unsigned NUM_LOC = 5;
    localparam logic [3:0]  IRQ_NUM = 4'd11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        active_valid = 1'b0;
    logic [2:0]  active_loc = '0;
    logic [2:0]  acc_loc = '0;
    logic [1:0]  acc_sel = '0;
    logic [1:0]  acc_off = '0;
    logic [1:0]  acc_size = 2'd2;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  ev_loc = 3'd7;
    logic [3:0]  ev_src = '0;
    logic        irq_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    irq_enable_status_unit #(.NUM_LOC(NUM_LOC), .IRQ_NUM(IRQ_NUM)) i_irq_enable_status_unit (
        .clk(clk), .rst_n(rst_n), .active_valid(active_valid), .active_loc(active_loc),
        .acc_loc(acc_loc), .acc_sel(acc_sel), .acc_off(acc_off), .acc_size(acc_size),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ev_loc(ev_loc), .ev_src(ev_src), .irq_req(irq_req)
    );

    typedef struct packed {
        logic        is_ev;
        logic [2:0]  loc;
        logic [1:0]  sel;
        logic [1:0]  off;
        logic [1:0]  sz;
        logic [31:0] data;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 3'd1, 2'd0, 2'd0, 2'd2, 32'hFFFF_FFFF, 32'h8000_009F, 1'b0, 4'd2}, // R2
        '{1'b1, 3'd1, 2'd1, 2'd0, 2'd2, 32'h0000_0001, 32'h0000_0001, 1'b1, 4'd3}, // R3
        '{1'b0, 3'd1, 2'd1, 2'd0, 2'd2, 32'h0000_0001, 32'h0000_0000, 1'b0, 4'd4}, // R4
        '{1'b0, 3'd1, 2'd0, 2'd3, 2'd0, 32'h0000_0000, 32'h0000_009F, 1'b0, 4'd8}, // R8
        '{1'b1, 3'd1, 2'd1, 2'd0, 2'd2, 32'h0000_000F, 32'h0000_0000, 1'b0, 4'd3}, // R3
        '{1'b0, 3'd1, 2'd0, 2'd3, 2'd0, 32'h0000_0080, 32'h8000_009F, 1'b0, 4'd8}, // R8
        '{1'b0, 3'd1, 2'd0, 2'd0, 2'd0, 32'h0000_0001, 32'h8000_0001, 1'b0, 4'd8}, // R8
        '{1'b1, 3'd1, 2'd1, 2'd0, 2'd2, 32'h0000_0006, 32'h0000_0000, 1'b0, 4'd3}, // R3
        '{1'b1, 3'd1, 2'd1, 2'd0, 2'd2, 32'h0000_0009, 32'h0000_0001, 1'b1, 4'd3}, // R3
        '{1'b0, 3'd0, 2'd0, 2'd0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0008, 1'b1, 4'd5}, // R5
        '{1'b0, 3'd1, 2'd2, 2'd0, 2'd2, 32'h0000_0005, 32'h0000_000B, 1'b1, 4'd6}, // R6
        '{1'b0, 3'd1, 2'd1, 2'd2, 2'd1, 32'h0000_FFFF, 32'h0000_0001, 1'b1, 4'd8}, // R8
        '{1'b0, 3'd1, 2'd1, 2'd0, 2'd0, 32'h0000_0001, 32'h0000_0000, 1'b0, 4'd4}  // R4
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] loc, input logic [1:0] sel, input logic [1:0] off,
                            input logic [1:0] sz, input logic [31:0] data);
        @(negedge clk);
        acc_loc = loc; acc_sel = sel; acc_off = off; acc_size = sz; wr_data = data; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic do_event(input logic [2:0] loc, input logic [3:0] src);
        @(negedge clk);
        ev_loc = loc; ev_src = src;
        @(negedge clk);
        ev_src = '0; ev_loc = 3'd7;
        #1;
    endtask

    task automatic look(input logic [2:0] loc, input logic [1:0] sel);
        acc_loc = loc; acc_sel = sel;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset values of every locality
        for (int l = 0; l < int'(NUM_LOC); l++) begin
            look(3'(l), 2'd0); check("R7 enable reset", rd_data, 32'h0000_0008);
            look(3'(l), 2'd1); check("R7 status reset", rd_data, 32'h0000_0000);
        end
        check("R7 irq reset", {31'd0, irq_req}, 32'd0);

        // R1: reserved select and locality with no registers read zero
        look(3'd1, 2'd3); check("R1 reserved select", rd_data, 32'h0);
        look(3'd6, 2'd0); check("R1 out-of-range locality", rd_data, 32'h0);
        look(3'd2, 2'd2); check("R6 vector read", rd_data, 32'h0000_000B);

        active_valid = 1'b1; active_loc = 3'd1;

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].is_ev) do_event(TBL[i].loc, TBL[i].data[3:0]);
            else do_write(TBL[i].loc, TBL[i].sel, TBL[i].off, TBL[i].sz, TBL[i].data);
            look(TBL[i].loc, TBL[i].sel);
            check($sformatf("R%0d table step %0d rd", TBL[i].req, i), rd_data, TBL[i].exp_rd);
            check($sformatf("R%0d table step %0d irq", TBL[i].req, i), {31'd0, irq_req}, {31'd0, TBL[i].exp_irq});
        end

        // R9: events for a locality with no owner are dropped
        do_event(3'd6, 4'hF);
        check("R9 irq after dropped event", {31'd0, irq_req}, 32'd0);
        look(3'd1, 2'd1); check("R9 status unchanged", rd_data, 32'h0);

        // R5: no owner, status clear ignored
        do_event(3'd1, 4'h1);
        check("R3 irq after event", {31'd0, irq_req}, 32'd1);
        active_valid = 1'b0;
        do_write(3'd1, 2'd1, 2'd0, 2'd2, 32'hFFFF_FFFF);
        look(3'd1, 2'd1); check("R5 no-owner clear ignored", rd_data, 32'h1);
        check("R5 irq held", {31'd0, irq_req}, 32'd1);
        active_valid = 1'b1;

        // R4: clear and event in the same cycle, event wins
        @(negedge clk);
        acc_loc = 3'd1; acc_sel = 2'd1; acc_off = 2'd0; acc_size = 2'd2;
        wr_data = 32'h1; wr_en = 1'b1; ev_loc = 3'd1; ev_src = 4'h1;
        @(negedge clk);
        wr_en = 1'b0; ev_src = '0; ev_loc = 3'd7;
        #1;
        check("R4 same-cycle event wins status", rd_data, 32'h1);
        check("R4 same-cycle event wins irq", {31'd0, irq_req}, 32'd1);
        do_write(3'd1, 2'd1, 2'd0, 2'd2, 32'h1);
        look(3'd1, 2'd1); check("R4 final clear status", rd_data, 32'h0);
        check("R4 final clear irq", {31'd0, irq_req}, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule